// File: doc/BRIEF.md
# Branch Hazard Fetch Controller

This block steers the fetch address of a five-stage in-order pipeline around conditional branches. It watches for a branch sitting in the decode stage and for the strobe that carries the branch's resolved outcome and target. From these it decides each cycle whether the fetch stage advances sequentially, holds its address, or jumps to the target. It can also tell the pipeline to turn the instruction in the fetch/decode register into a bubble.

A two-bit policy input, fixed while the block is in reset, picks how branches are handled:

- **Freeze:** fetch waits until the branch outcome is known.
- **Predict-not-taken:** fetch runs on sequentially, and a taken branch pays for one wrong-path instruction, which is squashed.
- **Delay slot:** the instruction right after the branch always runs and nothing is stalled or squashed.

Target arithmetic, condition evaluation and any form of dynamic or taken prediction live outside the block.

The controller has three states:

- **ST_RUN:** normal sequential fetch.
- **ST_HOLD:** a freeze is waiting for its resolution.
- **ST_KILL:** the single squash cycle after a taken branch in predict-not-taken policy.

The state transitions are:

- **ST_RUN to ST_HOLD:** a branch is in decode under freeze policy with no resolution yet.
- **ST_HOLD to ST_RUN:** the resolution arrives.
- **ST_RUN to ST_KILL:** a taken resolution arrives under predict-not-taken policy.
- **ST_KILL to ST_RUN:** unconditional, after one cycle.

Every other case stays in ST_RUN.

Top module: `branch_fetch_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, fetch_pc is 0, fetch_stall is 0 and fd_squash is 0.
- R2: With no branch activity, fetch_pc increases by 4 on every clock edge, and fetch_stall and fd_squash stay 0.
- R3: With policy freeze (mode_sel = 0), a branch in decode with no resolution drives fetch_stall to 1. fetch_pc holds its value each cycle until resolve_vld arrives.
- R4: With policy freeze, in the resolving cycle a taken outcome gives fetch_stall = 1 and fetch_pc = target_addr on the next edge. A not-taken outcome gives fetch_stall = 0 and a sequential step of 4.
- R5: With policy predict-not-taken (mode_sel = 1), a not-taken branch costs nothing: fetch_stall and fd_squash stay 0 and fetch_pc steps by 4.
- R6: With policy predict-not-taken, a taken branch loads target_addr into fetch_pc on the next edge. fd_squash is high for exactly that following cycle, and fetch_stall never rises.
- R7: With policy delay slot (mode_sel = 2), fetch_stall and fd_squash stay 0 whatever the outcome. A taken branch loads target_addr into fetch_pc on the next edge, so the instruction fetched during the branch's decode cycle always executes.
- R8: During the squash cycle, br_in_dec is ignored and fetch_pc advances by 4.
- R9: mode_sel = 3 is treated as freeze.
- R10: resolve_vld is only asserted together with br_in_dec. Under the two speculative policies, resolution arrives in the same cycle as br_in_dec, except during a squash cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Branch policy: 0 freeze, 1 predict-not-taken, 2 delay slot, 3 freeze |
| br_in_dec | input | 1 | A branch occupies the decode stage |
| resolve_vld | input | 1 | Branch outcome and target are valid this cycle |
| resolve_taken | input | 1 | Resolved outcome is taken |
| target_addr | input | ADDR_W | Resolved branch target |
| fetch_pc | output | ADDR_W | Address fetched this cycle |
| fetch_stall | output | 1 | Fetch/decode register must not capture this cycle |
| fd_squash | output | 1 | Clear the valid bit of the fetch/decode register |

## Verification
The assertions assume resolve_vld never appears without a branch in decode. They also assume that, under the speculative policies, the outcome is ready in the branch's own decode cycle. Beyond that, they assume mode_sel only changes during reset. The stimulus keeps to this contract by changing the policy only inside a reset sequence and pairing every resolution with a held br_in_dec. It holds back resolution only under freeze policy. The only branch indication raised without a resolution under a speculative policy is raised during a squash cycle, where it must be ignored.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

    typedef enum logic [1:0] {
        POL_FREEZE     = 2'd0,
        POL_NOT_TAKEN  = 2'd1,
        POL_DELAY_SLOT = 2'd2,
        POL_RSVD       = 2'd3
    } policy_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_KILL = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        NPC_SEQ    = 2'd0,
        NPC_HOLD   = 2'd1,
        NPC_TARGET = 2'd2
    } npc_sel_e;

endpackage

// File: rtl/bfc_pc_reg.sv
module bfc_pc_reg #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  bfc_pkg::npc_sel_e    sel,
    input  logic [ADDR_W-1:0]    target,
    output logic [ADDR_W-1:0]    pc
);
    localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else begin
            unique case (sel)
                bfc_pkg::NPC_SEQ:    pc <= pc + INC;
                bfc_pkg::NPC_HOLD:   pc <= pc;
                bfc_pkg::NPC_TARGET: pc <= target;
                default:             pc <= pc + INC;
            endcase
        end
    end
endmodule

// File: rtl/bfc_fsm.sv
module bfc_fsm (
    input  logic               clk,
    input  logic               rst_n,
    input  bfc_pkg::policy_e   policy,
    input  logic               br_in_dec,
    input  logic               resolve_vld,
    input  logic               resolve_taken,
    output bfc_pkg::npc_sel_e  npc_sel,
    output logic               fetch_stall,
    output logic               fd_squash
);
    import bfc_pkg::*;

    state_e state, state_nxt;
    logic   freezeish;
    logic   taken_now;

    assign freezeish = (policy == POL_FREEZE) || (policy == POL_RSVD);
    assign taken_now = resolve_vld && resolve_taken;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN: begin
                if (br_in_dec) begin
                    if (freezeish && !resolve_vld)
                        state_nxt = ST_HOLD;
                    else if (!freezeish && taken_now && policy == POL_NOT_TAKEN)
                        state_nxt = ST_KILL;
                end
            end
            ST_HOLD: if (resolve_vld) state_nxt = ST_RUN;
            ST_KILL: state_nxt = ST_RUN;
            default: state_nxt = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        npc_sel     = NPC_SEQ;
        fetch_stall = 1'b0;
        fd_squash   = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (br_in_dec) begin
                    if (freezeish) begin
                        fetch_stall = !resolve_vld || resolve_taken;
                        if (!resolve_vld)  npc_sel = NPC_HOLD;
                        else if (taken_now) npc_sel = NPC_TARGET;
                    end else if (taken_now) begin
                        npc_sel = NPC_TARGET;
                    end
                end
            end
            ST_HOLD: begin
                fetch_stall = !resolve_vld || resolve_taken;
                if (!resolve_vld)   npc_sel = NPC_HOLD;
                else if (taken_now) npc_sel = NPC_TARGET;
            end
            ST_KILL: fd_squash = 1'b1;
            default: npc_sel = NPC_SEQ;
        endcase
    end

    assert_freeze_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (freezeish && br_in_dec && !resolve_vld) |-> fetch_stall);

    assert_pnt_nostall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POL_NOT_TAKEN) |-> !fetch_stall);

    assert_squash_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fd_squash |-> ($past(taken_now) && policy == POL_NOT_TAKEN));

    assert_squash_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fd_squash |=> !fd_squash);

    assert_delay_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POL_DELAY_SLOT) |-> (!fetch_stall && !fd_squash));

    assert_no_stray_resolve_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resolve_vld |-> br_in_dec);

    assert_spec_same_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!freezeish && br_in_dec && !fd_squash) |-> resolve_vld);

    assert_policy_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(policy));
endmodule

// File: rtl/branch_fetch_ctrl.sv
module branch_fetch_ctrl #(
    parameter int ADDR_W      = 32,
    parameter int INSTR_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              br_in_dec,
    input  logic              resolve_vld,
    input  logic              resolve_taken,
    input  logic [ADDR_W-1:0] target_addr,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic              fetch_stall,
    output logic              fd_squash
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    bfc_pkg::policy_e  policy;
    bfc_pkg::npc_sel_e npc_sel;

    assign policy = bfc_pkg::policy_e'(mode_sel);

    bfc_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .policy        (policy),
        .br_in_dec     (br_in_dec),
        .resolve_vld   (resolve_vld),
        .resolve_taken (resolve_taken),
        .npc_sel       (npc_sel),
        .fetch_stall   (fetch_stall),
        .fd_squash     (fd_squash)
    );

    bfc_pc_reg #(
        .ADDR_W (ADDR_W),
        .STEP   (INSTR_BYTES)
    ) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (npc_sel),
        .target (target_addr),
        .pc     (fetch_pc)
    );

    assert_seq_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_stall && !(resolve_vld && resolve_taken && !fd_squash))
        |=> (fetch_pc == $past(fetch_pc) + STEP));

    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stall && !resolve_vld) |=> $stable(fetch_pc));

    // covers R4, R6 and R7: a taken resolution redirects on the next edge
    assert_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_in_dec && resolve_vld && resolve_taken && !fd_squash)
        |=> (fetch_pc == $past(target_addr)));
endmodule

// File: tb/tb_branch_fetch_ctrl.sv
`timescale 1ns/1ps
module tb_branch_fetch_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic        br_in_dec = 1'b0;
    logic        resolve_vld = 1'b0;
    logic        resolve_taken = 1'b0;
    logic [31:0] target_addr = '0;
    logic [31:0] fetch_pc;
    logic        fetch_stall;
    logic        fd_squash;

    int checks = 0;
    int errors = 0;

    // reference model state
    int unsigned m_pc;
    bit          m_kill;
    int          m_mode;

    always #4 clk = ~clk;

    branch_fetch_ctrl dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .br_in_dec(br_in_dec),
        .resolve_vld(resolve_vld), .resolve_taken(resolve_taken),
        .target_addr(target_addr), .fetch_pc(fetch_pc),
        .fetch_stall(fetch_stall), .fd_squash(fd_squash)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset(input int mode);
        rst_n = 1'b0;
        mode_sel = mode[1:0];
        br_in_dec = 1'b0; resolve_vld = 1'b0; resolve_taken = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "pc in reset", fetch_pc, 32'd0);
        rst_n = 1'b1;
        m_pc = 0; m_kill = 0; m_mode = mode;
        #1;
        chk("R1", "pc after reset", fetch_pc, 32'd0);
        chk("R1", "stall after reset", {31'd0, fetch_stall}, 32'd0);
        chk("R1", "squash after reset", {31'd0, fd_squash}, 32'd0);
    endtask

    task automatic step(input logic br, input logic rv, input logic rt,
                        input logic [31:0] tgt, input string tag);
        bit frz;
        bit e_stall;
        br_in_dec = br; resolve_vld = rv; resolve_taken = rt; target_addr = tgt;
        #1;
        frz = (m_mode == 0) || (m_mode == 3);
        e_stall = !m_kill && frz && br && (!rv || rt);
        chk(tag, "fetch_pc", fetch_pc, m_pc);
        chk(tag, "fetch_stall", {31'd0, fetch_stall}, {31'd0, e_stall});
        chk(tag, "fd_squash", {31'd0, fd_squash}, {31'd0, m_kill});
        @(posedge clk);
        if (m_kill) begin
            m_pc += 4; m_kill = 0;
        end else if (br && rv && rt) begin
            m_pc = tgt; m_kill = (m_mode == 1);
        end else if (!e_stall) begin
            m_pc += 4;
        end
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // freeze
        do_reset(0);
        step(0,0,0,0,"R2"); step(0,0,0,0,"R2"); step(0,0,0,0,"R2");
        step(1,1,0,32'h40,"R4");                                 // resolved not taken at once
        step(0,0,0,0,"R2");
        step(1,0,0,0,"R3"); step(1,0,0,0,"R3"); step(1,1,1,32'h200,"R4");
        step(0,0,0,0,"R2");
        step(1,1,1,32'h300,"R4");                                // immediate taken
        step(0,0,0,0,"R2");
        step(1,0,0,0,"R3"); step(1,1,0,32'h999,"R4");
        step(0,0,0,0,"R2");
        // predict-not-taken
        do_reset(1);
        step(0,0,0,0,"R2");
        step(1,1,0,32'h80,"R5"); step(0,0,0,0,"R5");
        step(1,1,1,32'h1000,"R6");
        step(0,0,0,0,"R6");                                      // squash cycle
        step(0,0,0,0,"R6");
        step(1,1,1,32'h2000,"R6");
        step(1,0,0,0,"R8");                                      // branch ignored while squashing
        step(0,0,0,0,"R8");
        step(1,1,0,32'h55,"R5");
        // delay slot
        do_reset(2);
        step(0,0,0,0,"R2");
        step(1,1,1,32'h500,"R7"); step(0,0,0,0,"R7");
        step(1,1,0,32'h700,"R7"); step(0,0,0,0,"R7");
        step(1,1,1,32'h900,"R7"); step(1,1,1,32'hA00,"R7"); step(0,0,0,0,"R7");
        // reserved code behaves as freeze
        do_reset(3);
        step(0,0,0,0,"R9");
        step(1,0,0,0,"R9"); step(1,0,0,0,"R9"); step(1,1,1,32'hC00,"R9");
        step(0,0,0,0,"R9");
        step(1,1,0,32'h10,"R9"); step(0,0,0,0,"R9");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule